// File: doc/BRIEF.md
# Interrupt Steering and Sensitivity Unit

This unit conditions the sixteen interrupt request lines that feed a cascaded pair of eight-input interrupt controllers. Four shared, active-low PCI-style interrupt lines can each be steered onto any IRQ number. Steered lines are inverted to active-high and ORed with the dedicated source on that IRQ. Each IRQ is then treated as either edge-triggered or active-low level-sensitive, according to a per-IRQ sensitivity bit.

Software programs the unit through a small byte-wide register port. Two sensitivity bytes and four steering bytes are written and read back there. The sixteen outputs are active-high requests for the downstream controllers. An edge-mode request is held until that controller acknowledges it. IRQ2 carries the cascade from the second controller, which is produced downstream, so this unit always drives it low. IRQ0, IRQ2, IRQ8 and IRQ13 are tied to internal functions and can never be steering targets.

Top module: `irq_steer`

## Requirements
- R1: After reset every register reads 0 (all IRQs in edge mode, all steering disabled) and `irq_req` is all zero.
- R2: The register port decodes `reg_addr` as follows. Address 0 holds the sensitivity bits for IRQ0..7 and address 1 holds them for IRQ8..15; bit n of the byte covers the nth IRQ of that group, and 1 selects level mode. Addresses 2, 3, 4 and 5 steer PCI inputs 0..3, with bit 7 as the enable and bits 3:0 as the target IRQ. Bits 6:4 of a steering byte and all other addresses read 0. A write takes effect at the clock edge where `reg_we` is high, and `reg_rdata` is combinational.
- R3: IRQ and PCI pins pass through a two-flop synchronizer. A level-mode request follows a pin change at the second rising clock edge after it.
- R4: In level mode an IRQ pin is active low: the request is high while the synchronized pin is 0.
- R5: In edge mode a rising edge of the normalized request sets a pending request that stays high until `irq_ack` for that IRQ is high at a clock edge. A rise coinciding with an acknowledge leaves the request set.
- R6: An enabled PCI input held low raises its target IRQ. Several sources on one IRQ are ORed, so the request stays high while any of them is asserted. A disabled steering entry has no effect.
- R7: Steering targets 0, 2, 8 and 13 route the PCI input nowhere.
- R8: `irq_req[2]` is always 0, whatever the IRQ2 pin does.
- R9: Switching an IRQ from edge to level mode discards its pending edge request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_pin | input | 16 | Dedicated IRQ source pins, asynchronous |
| pci_int_n | input | 4 | Shared active-low PCI interrupt lines, asynchronous |
| irq_ack | input | 16 | Per-IRQ acknowledge from the controllers |
| irq_req | output | 16 | Normalized active-high requests to the controllers |

## Verification
The bench measures the synchronizer latency cycle by cycle. A design with one stage too few or too many raises the level request a cycle early or late. It places an acknowledge in the same cycle as a detected rise, where a design that lets the acknowledge win would drop an interrupt. It overlaps two PCI lines on one IRQ and releases them one at a time, catching a design that lets the last writer win instead of ORing the sources. It also steers onto every reserved IRQ, toggles the IRQ2 pin, and switches a pending IRQ to level mode. These expose leaks into reserved numbers and stale edge requests that survive a mode change.

// File: rtl/irq_steer.sv
module irq_steer #(
  parameter int NIRQ = 16,
  parameter int NPCI = 4,
  parameter int AW   = 3,
  parameter int DW   = 8,
  parameter int CASC = 2,
  parameter logic [NIRQ-1:0] RSVD = 16'h2105
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NIRQ-1:0] irq_pin,
  input  logic [NPCI-1:0] pci_int_n,
  input  logic [NIRQ-1:0] irq_ack,
  output logic [NIRQ-1:0] irq_req
);
  localparam int IW = $clog2(NIRQ);
  localparam int NSB = NIRQ / DW;
  localparam logic [NIRQ-1:0] CMASK = NIRQ'(1) << CASC;

  logic [NIRQ-1:0] level_sel;
  logic [NPCI-1:0] route_en;
  logic [IW-1:0]   route_tgt [NPCI];

  logic [NIRQ-1:0] pin_s1, pin_s2, norm_d, pend;
  logic [NPCI-1:0] pci_s1, pci_s2;
  logic [NIRQ-1:0] steer_hit, norm, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_sel <= '0;
      route_en  <= '0;
      for (int p = 0; p < NPCI; p++) route_tgt[p] <= '0;
    end else if (reg_we) begin
      for (int b = 0; b < NSB; b++)
        if (reg_addr == AW'(b)) level_sel[b*DW +: DW] <= reg_wdata;
      for (int p = 0; p < NPCI; p++)
        if (reg_addr == AW'(NSB + p)) begin
          route_en[p]  <= reg_wdata[DW-1];
          route_tgt[p] <= reg_wdata[IW-1:0];
        end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NSB; b++)
      if (reg_addr == AW'(b)) reg_rdata = level_sel[b*DW +: DW];
    for (int p = 0; p < NPCI; p++)
      if (reg_addr == AW'(NSB + p)) begin
        reg_rdata[DW-1]   = route_en[p];
        reg_rdata[IW-1:0] = route_tgt[p];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1 <= '0;
      pin_s2 <= '0;
      pci_s1 <= '1;
      pci_s2 <= '1;
    end else begin
      pin_s1 <= irq_pin;
      pin_s2 <= pin_s1;
      pci_s1 <= pci_int_n;
      pci_s2 <= pci_s1;
    end
  end

  always_comb begin
    steer_hit = '0;
    for (int p = 0; p < NPCI; p++)
      if (route_en[p] && !pci_s2[p] && !RSVD[route_tgt[p]])
        steer_hit[route_tgt[p]] = 1'b1;
  end

  assign norm = (pin_s2 ^ level_sel) | steer_hit;
  assign rise = norm & ~norm_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_d <= '0;
      pend   <= '0;
    end else begin
      norm_d <= norm;
      pend   <= ((pend & ~irq_ack) | rise) & ~level_sel;
    end
  end

  assign irq_req = ((level_sel & norm) | (~level_sel & pend)) & ~CMASK;
endmodule

module irq_steer_chk #(
  parameter int NIRQ = 16,
  parameter int AW   = 3,
  parameter int DW   = 8,
  parameter int CASC = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [AW-1:0]   reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic [NIRQ-1:0] irq_ack,
  input logic [NIRQ-1:0] irq_req,
  input logic [NIRQ-1:0] level_sel,
  input logic [NIRQ-1:0] rise
);
  p_cascade_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req[CASC]);

  p_sens_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0) |=> level_sel[DW-1:0] == $past(reg_wdata));

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_sel[i] && irq_req[i] && !irq_ack[i]) |=> (irq_req[i] || level_sel[i]));
    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_sel[i] && irq_ack[i] && !rise[i]) |=> (!irq_req[i] || level_sel[i]));
  end
endmodule

bind irq_steer irq_steer_chk #(.NIRQ(NIRQ), .AW(AW), .DW(DW), .CASC(CASC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_ack(irq_ack), .irq_req(irq_req),
  .level_sel(level_sel), .rise(rise)
);

// File: tb/tb_irq_steer.sv
module tb_irq_steer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] irq_pin = '0;
  logic [3:0]  pci_int_n = '1;
  logic [15:0] irq_ack = '0;
  logic [15:0] irq_req;

  int checks = 0;
  int fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_steer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pin(irq_pin),
    .pci_int_n(pci_int_n), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  always @(posedge clk) begin
    #2;
    while (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (irq_req !== e) begin
        fails++;
        $display("FAIL %s: irq_req=%h expected %h", t, irq_req, e);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_req(input logic [15:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL %s: rdata[%0d]=%h expected %h", t, a, reg_rdata, e);
    end
  endtask

  task automatic ack(input int i);
    @(negedge clk);
    irq_ack[i] = 1;
    @(negedge clk);
    irq_ack[i] = 0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    expect_req(16'h0000, "R1 reset outputs");
    for (int a = 0; a < 8; a++) rd_check(3'(a), 8'h00, "R1 R2 reset readback");

    // edge mode on IRQ5: rise, hold, ack
    irq_pin[5] = 1;
    step(3);
    expect_req(16'h0020, "R5 edge rise sets");
    irq_pin[5] = 0;
    step(3);
    expect_req(16'h0020, "R5 held after pin falls");
    ack(5);
    expect_req(16'h0000, "R5 ack clears");

    // rise coincides with ack on IRQ6
    @(negedge clk); irq_pin[6] = 1;
    @(negedge clk);
    @(negedge clk); irq_ack[6] = 1;
    @(negedge clk); irq_ack[6] = 0;
    expect_req(16'h0040, "R5 rise wins over ack");
    ack(6);
    irq_pin[6] = 0;
    step(3);
    expect_req(16'h0000, "R5 cleared after second ack");

    // IRQ3: pending edge discarded on switch to level
    irq_pin[3] = 1;
    step(3);
    expect_req(16'h0008, "R5 IRQ3 pending");
    wr(3'd0, 8'h08);
    step(1);
    expect_req(16'h0000, "R9 level switch drops pending");
    rd_check(3'd0, 8'h08, "R2 sens low readback");

    // level active low with synchronizer latency
    @(negedge clk); irq_pin[3] = 0;
    expect_req(16'h0000, "R3 not yet after one edge");
    @(negedge clk);
    expect_req(16'h0008, "R3 R4 level asserted after two edges");
    step(3);
    expect_req(16'h0008, "R4 level stays while pin low");
    irq_pin[3] = 1;
    step(3);
    expect_req(16'h0000, "R4 level released");

    // IRQ9 to level mode, then steering
    irq_pin[9] = 1;
    step(3);
    expect_req(16'h0200, "R5 IRQ9 pending");
    wr(3'd1, 8'h02);
    step(1);
    expect_req(16'h0000, "R9 IRQ9 switched to level");
    rd_check(3'd1, 8'h02, "R2 sens high readback");
    wr(3'd2, 8'h89);
    rd_check(3'd2, 8'h89, "R2 steer A readback");
    pci_int_n[0] = 0;
    step(3);
    expect_req(16'h0200, "R6 PCI A steered to IRQ9");
    wr(3'd3, 8'h89);
    pci_int_n[1] = 0;
    step(1);
    pci_int_n[0] = 1;
    step(3);
    expect_req(16'h0200, "R6 OR keeps IRQ9 while B low");
    pci_int_n[1] = 1;
    step(3);
    expect_req(16'h0000, "R6 IRQ9 released when all high");
    wr(3'd2, 8'hF9);
    rd_check(3'd2, 8'h89, "R2 unused steering bits read 0");

    // reserved targets
    wr(3'd4, 8'h8D);
    pci_int_n[2] = 0;
    step(3);
    expect_req(16'h0000, "R7 target 13 routes nowhere");
    wr(3'd4, 8'h88);
    step(3);
    expect_req(16'h0000, "R7 target 8 routes nowhere");
    wr(3'd4, 8'h82);
    step(3);
    expect_req(16'h0000, "R7 target 2 routes nowhere");
    wr(3'd4, 8'h80);
    step(3);
    expect_req(16'h0000, "R7 target 0 routes nowhere");
    wr(3'd4, 8'h8B);
    step(3);
    expect_req(16'h0800, "R6 PCI C to IRQ11 edge");
    pci_int_n[2] = 1;
    step(3);
    expect_req(16'h0800, "R5 IRQ11 held after release");
    ack(11);
    expect_req(16'h0000, "R5 IRQ11 acked");

    // disabled entry
    wr(3'd5, 8'h0A);
    pci_int_n[3] = 0;
    step(3);
    expect_req(16'h0000, "R6 disabled steering ignored");
    rd_check(3'd5, 8'h0A, "R2 steer D readback");
    pci_int_n[3] = 1;

    // cascade line
    irq_pin[2] = 1;
    step(3);
    expect_req(16'h0000, "R8 IRQ2 pin ignored");
    irq_pin[2] = 0;
    step(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule